// File: doc/BRIEF.md
# Countdown Timer with Acknowledged Interrupt

This block is a single down-counting timer that software controls over a small register bus. Each access carries a word index, a select, a write flag and a data word. Reads are answered combinationally in the same cycle. Software stores a start value, then sets the enable bit in a control word. While enabled, the counter drops by one on every clock. When the count reaches zero it either reloads the stored value or wraps to all ones. In both cases it raises a pending flag.

The pending flag drives a level interrupt, gated by a mask bit in the control word. The flag stays set until software reads a dedicated acknowledge register. Software can read the live count at any time; a rising timestamp is the bitwise inverse of the count. To reprogram the count, software stops the timer, writes the new start value, and enables the timer again.

The sequencer has two states. `ST_STOP` holds the count frozen. `ST_RUN` decrements the count. The transition *start* (`ST_STOP` to `ST_RUN`) happens on a control write with the enable bit set, and it copies the start value into the counter. The transition *halt* (`ST_RUN` to `ST_STOP`) happens on a control write with the enable bit clear. In `ST_RUN`, a control write with the enable bit set is the transition *retune*: the timer stays in `ST_RUN`, the mode and mask bits change, and the count is not reloaded.

Top module: `count_timer`

## Requirements
- R1: After reset, the start value, the count, the control word and the pending flag are all zero, and `irq` is low.
- R2: Word index 0 holds the start value and word index 2 holds the control word. Control bit 0 is enable, bit 1 is reload mode (1) or free mode (0), and bit 2 is mask. Both registers read back what was last written; the control word reads back in bits [2:0] with the upper bits zero.
- R3: A control write with bit 0 set while stopped loads the start value into the count at that clock edge. From then on the count, read at word index 1, drops by one on every clock.
- R4: In reload mode, a running count of zero is replaced by the start value on the next clock. A start value of N therefore expires once every N+1 clocks.
- R5: In free mode, a running count of zero becomes 0xFFFFFFFF on the next clock. With a start value of 0xFFFFFFFF the counter cycles through the whole 32-bit range.
- R6: Each expiry, meaning a count of zero while running and not being halted, sets the pending flag. The flag holds until it is acknowledged. If an expiry and an acknowledge fall on the same edge, the flag stays set.
- R7: A read of word index 3 returns zero and clears the pending flag at that clock edge.
- R8: Word index 4 reads, in bit 0, the pending flag ANDed with the inverse of the mask bit, and `irq` carries the same value. Masking does not clear the flag, so clearing the mask exposes a flag that is still pending.
- R9: A control write with bit 0 clear freezes the count at its current value. A control write with bit 0 set while already running changes the mode and mask without reloading the count.
- R10: Writes to word indexes 1, 3 and 4 change no state. Reads of word indexes 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| irq | output | 1 | Level interrupt: the pending flag with the mask applied |

## Verification
The countdown is run in reload mode with a short start value, and the count is read back on every clock. This separates a correct N+1 period from off-by-one reload timing. Acknowledge reads are issued on every cycle across an expiry, which shows whether set or clear wins on a shared edge. Free mode is run with a small start value, so a wrong wrap value or a wrong reload choice shows up. The mask is toggled while a flag is still pending. Finally, writes to read-only indexes and retune writes during a run are issued, each followed by reads that would expose any hidden state change.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {ST_STOP = 1'b0, ST_RUN = 1'b1} tmr_state_e;

    // word indexes on the register bus
    localparam int REG_LOAD = 0;
    localparam int REG_CUR  = 1;
    localparam int REG_CTRL = 2;
    localparam int REG_EOI  = 3;
    localparam int REG_STAT = 4;

    // control word bit positions
    localparam int CTL_EN     = 0;
    localparam int CTL_RELOAD = 1;
    localparam int CTL_MASK   = 2;
    localparam int CTL_W      = 3;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              pending,
    output logic [CNT_W-1:0]  load_val,
    output logic [CTL_W-1:0]  ctrl_q,
    output logic              ctrl_we,
    output logic              eoi_ack,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    logic load_we;
    logic visible;

    assign load_we = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(REG_LOAD));
    assign ctrl_we = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
    assign eoi_ack = bus_sel && !bus_wr && (bus_addr == ADDR_W'(REG_EOI));
    assign visible = pending && !ctrl_q[CTL_MASK];
    assign irq     = visible;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_val <= '0;
            ctrl_q   <= '0;
        end else begin
            if (load_we) load_val <= bus_wdata;
            if (ctrl_we) ctrl_q   <= bus_wdata[CTL_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                ADDR_W'(REG_LOAD): bus_rdata = load_val;
                ADDR_W'(REG_CUR):  bus_rdata = count;
                ADDR_W'(REG_CTRL): bus_rdata = CNT_W'(ctrl_q);
                ADDR_W'(REG_STAT): bus_rdata = CNT_W'(visible);
                default:           bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             en_wr,
    input  logic             reload_mode,
    input  logic [CNT_W-1:0] load_val,
    input  logic             eoi_ack,
    output logic [CNT_W-1:0] count,
    output logic             pending,
    output tmr_state_e       state
);
    tmr_state_e state_q, state_d;
    logic       running;
    logic       expire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (ctrl_we &&  en_wr) state_d = ST_RUN;   // start
            ST_RUN:  if (ctrl_we && !en_wr) state_d = ST_STOP;  // halt (retune keeps RUN)
            default: state_d = ST_STOP;
        endcase
    end

    assign running = (state_q == ST_RUN) && (state_d == ST_RUN);
    assign expire  = running && (count == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            pending <= 1'b0;
        end else begin
            if (state_q == ST_STOP && state_d == ST_RUN) begin
                count <= load_val;
            end else if (running) begin
                if (count == '0) count <= reload_mode ? load_val : '1;
                else             count <= count - 1'b1;
            end
            if (expire)       pending <= 1'b1;
            else if (eoi_ack) pending <= 1'b0;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/count_timer.sv
module count_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count;
    logic [CTL_W-1:0] ctrl_q;
    logic             ctrl_we;
    logic             eoi_ack;
    logic             pending;
    tmr_state_e       state;

    tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .count(count), .pending(pending),
        .load_val(load_val), .ctrl_q(ctrl_q), .ctrl_we(ctrl_we), .eoi_ack(eoi_ack),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .en_wr(bus_wdata[CTL_EN]), .reload_mode(ctrl_q[CTL_RELOAD]),
        .load_val(load_val), .eoi_ack(eoi_ack),
        .count(count), .pending(pending), .state(state)
    );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input tmr_state_e       state,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] load_val,
    input logic [CTL_W-1:0] ctrl_q,
    input logic             ctrl_we,
    input logic [CNT_W-1:0] bus_wdata,
    input logic             eoi_ack,
    input logic             pending,
    input logic             irq
);
    logic start_req, halt_req;
    assign start_req = ctrl_we &&  bus_wdata[CTL_EN] && state == ST_STOP;
    assign halt_req  = ctrl_we && !bus_wdata[CTL_EN] && state == ST_RUN;

    assert_start_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> count == $past(load_val));

    assert_count_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !halt_req && count != '0) |=> count == $past(count) - 1'b1);

    assert_reload_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !halt_req && count == '0 && ctrl_q[CTL_RELOAD]) |=> count == $past(load_val));

    assert_wrap_all_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !halt_req && count == '0 && !ctrl_q[CTL_RELOAD]) |=> count == '1);

    assert_expiry_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !halt_req && count == '0) |=> pending);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_ack && !(state == ST_RUN && !halt_req && count == '0)) |=> !pending);

    assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CTL_MASK] |-> !irq);

    assert_stop_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !start_req) |=> $stable(count));
endmodule

bind count_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .count(count), .load_val(load_val),
    .ctrl_q(ctrl_q), .ctrl_we(ctrl_we), .bus_wdata(bus_wdata), .eoi_ack(eoi_ack),
    .pending(pending), .irq(irq)
);

// File: tb/test_count_timer.sv
module test_count_timer;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic          irq;

    int n_checks = 0;
    int n_fails  = 0;
    string tag = "R1";
    bit done = 1'b0;

    // behavioural reference state
    logic [W-1:0] m_load = '0, m_cnt = '0;
    logic [2:0]   m_ctrl = '0;
    bit           m_run = 0, m_pend = 0;

    count_timer i_count_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst_n) begin
            bit rd_ack, cw, np;
            rd_ack = bus_sel && !bus_wr && bus_addr == 3'd3;
            cw     = bus_sel &&  bus_wr && bus_addr == 3'd2;
            np     = m_pend;
            if (rd_ack) np = 0;
            if (m_run) begin
                if (cw && !bus_wdata[0]) m_run = 0;
                else if (m_cnt == 0) begin
                    np = 1;
                    m_cnt = m_ctrl[1] ? m_load : 32'hFFFF_FFFF;
                end else m_cnt = m_cnt - 1;
            end else if (cw && bus_wdata[0]) begin
                m_run = 1;
                m_cnt = m_load;
            end
            m_pend = np;
            if (bus_sel && bus_wr && bus_addr == 3'd0) m_load = bus_wdata;
            if (cw) m_ctrl = bus_wdata[2:0];
        end
    end

    function automatic logic [W-1:0] model_read();
        if (!(bus_sel && !bus_wr)) return '0;
        case (bus_addr)
            3'd0: return m_load;
            3'd1: return m_cnt;
            3'd2: return {29'd0, m_ctrl};
            3'd4: return {31'd0, m_pend && !m_ctrl[2]};
            default: return '0;
        endcase
    endfunction

    task automatic compare();
        logic [W-1:0] exp_rd;
        logic exp_irq;
        exp_rd  = model_read();
        exp_irq = m_pend && !m_ctrl[2];
        n_checks++;
        if (irq !== exp_irq) begin
            n_fails++;
            $display("FAIL %s irq: actual %0b expected %0b at %0t", tag, irq, exp_irq, $time);
        end
        if (bus_sel && !bus_wr) begin
            n_checks++;
            if (bus_rdata !== exp_rd) begin
                n_fails++;
                $display("FAIL %s read idx %0d: actual %h expected %h at %0t",
                         tag, bus_addr, bus_rdata, exp_rd, $time);
            end
        end
    endtask

    task automatic op(input bit sel, input bit wr, input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1 compare();
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [W-1:0] d);
        op(1, 1, a, d);
    endtask

    task automatic rd_reg(input logic [2:0] a);
        op(1, 0, a, '0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(0, 0, 3'd0, '0);
    endtask

    task automatic watch(input int n);
        for (int i = 0; i < n; i++) rd_reg(3'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        tag = "R1";
        for (int a = 0; a < 5; a++) rd_reg(3'(a));
        // R10: unmapped reads
        tag = "R10";
        for (int a = 5; a < 8; a++) rd_reg(3'(a));
        // R2: register read back
        tag = "R2";
        wr_reg(3'd0, 32'h1234_5678); rd_reg(3'd0);
        wr_reg(3'd2, 32'hFFFF_FFF6); rd_reg(3'd2);
        wr_reg(3'd0, 32'd9); rd_reg(3'd0);
        // R3 / R4: start in reload mode, period N+1
        tag = "R3";
        wr_reg(3'd2, 32'd3);
        watch(5);
        tag = "R4";
        watch(20);
        // R6: flag holds without acknowledge
        tag = "R6";
        idle(12);
        // R7: acknowledge read clears
        tag = "R7";
        rd_reg(3'd3); rd_reg(3'd4);
        // R6: acknowledge on every cycle across an expiry
        tag = "R6";
        wr_reg(3'd2, 32'd6); wr_reg(3'd0, 32'd3); wr_reg(3'd2, 32'd3);
        for (int i = 0; i < 12; i++) rd_reg(3'd3);
        idle(2);
        // R10: writes to read-only indexes
        tag = "R10";
        wr_reg(3'd1, 32'hDEAD_BEEF); rd_reg(3'd1);
        wr_reg(3'd4, 32'h0); rd_reg(3'd4);
        wr_reg(3'd3, 32'h1); rd_reg(3'd4);
        // R9: halt freezes, retune keeps count
        tag = "R9";
        rd_reg(3'd3);
        wr_reg(3'd0, 32'd40); wr_reg(3'd2, 32'd6); wr_reg(3'd2, 32'd3);
        watch(3);
        wr_reg(3'd2, 32'd6); watch(4);
        wr_reg(3'd2, 32'd3); watch(3);
        wr_reg(3'd2, 32'd7); watch(3);
        wr_reg(3'd2, 32'd3); watch(2);
        // R5: free mode wrap from small start value
        tag = "R5";
        wr_reg(3'd2, 32'd6); wr_reg(3'd0, 32'd4); wr_reg(3'd2, 32'd1);
        watch(10);
        // R8: mask hides, unmask exposes
        tag = "R8";
        wr_reg(3'd2, 32'd5); rd_reg(3'd4); idle(2);
        wr_reg(3'd2, 32'd1); rd_reg(3'd4);
        rd_reg(3'd3); rd_reg(3'd4);
        // R5: full-range free running, masked
        tag = "R5";
        wr_reg(3'd2, 32'd6); wr_reg(3'd0, 32'hFFFF_FFFF); wr_reg(3'd2, 32'd5);
        watch(6);
        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule